// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This unit is the last stage of a single-precision floating-point datapath. An arithmetic stage hands it a sign, an unbiased signed exponent and a 27-bit working significand. That significand carries the hidden bit at bit 26, then 23 fraction bits, then three extra bits at the bottom (guard, round and sticky). The unit rounds the value in one of four directed modes and returns an IEEE-754 single-precision word together with inexact, underflow and overflow flags. Along the way it denormalizes tiny values, follows a rounding carry into the exponent, saturates on overflow according to the mode and the sign, and can flush tiny values to zero.

Each input word is accepted on a cycle where `in_valid` is high. The packed result and the flags are registered and appear one clock later, marked by `out_valid`. The input significand must be normalized (bit 26 set). NaN operands and an all-zero significand are not handled here. Exception traps are not raised here; the trap-enable input only changes when underflow is reported.

Top module: `sp_round_pack`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no input, `out_valid`, `out_result` and all three flags are 0.
- R2: `out_valid` equals `in_valid` from the previous clock edge. The result and the flags for an input appear on the same edge as its `out_valid`.
- R3: `rnd_mode` selects the rounding: 0 is nearest, 1 is toward zero, 2 is toward plus infinity, 3 is toward minus infinity. Toward zero never increments. Toward plus infinity increments the magnitude only for a positive value with discarded bits. Toward minus infinity increments it only for a negative value with discarded bits.
- R4: In nearest mode a discarded part above one half rounds up and one below one half rounds down. An exact half goes to the neighbour whose least significant kept bit is 0.
- R5: `out_inexact` is 1 whenever the discarded bits of the (possibly denormalized) significand are nonzero. It is also 1 on overflow and on a flush. A result with nothing discarded is returned unchanged with the flag at 0.
- R6: With `flush_en` = 1 and an exponent below -126, the result is produced with underflow and inexact both set. Nearest and toward-zero give a zero with the input sign. Toward plus infinity gives 0x00000001 for a positive value and 0x80000000 for a negative one. Toward minus infinity gives 0x00000000 for a positive value and 0x80000001 for a negative one.
- R7: With the exponent at -127 and flush off, if rounding the undenormalized significand carries out of bit 26, the result is the smallest normal number with the input sign (exponent field 1, fraction 0), with inexact set and underflow clear.
- R8: For any other exponent below -126, the significand is shifted right by (-126 - exponent) with all lost bits ORed into the lowest bit. It is then rounded at exponent -126. When this is inexact, underflow is set. A result whose hidden bit is still clear is encoded with exponent field 0.
- R9: When `uf_trap_en` = 1, a result encoded with exponent field 0 sets underflow even if it is exact. When `uf_trap_en` = 0, an exact result never sets underflow.
- R10: A rounding carry out of bit 26 shifts the significand right by one place and adds one to the exponent. This carry also turns the largest denormal into the smallest normal (exponent field 1).
- R11: A rounded exponent above +127 sets overflow and inexact. Nearest gives signed infinity and toward zero gives the signed largest finite value (field 0xFE, fraction all ones). Toward plus infinity gives +infinity or the negative largest finite value. Toward minus infinity gives the positive largest finite value or -infinity.
- R12: A normal result packs as {sign, exponent + 127, fraction without the hidden bit}, with bit 31 as the sign and bits 30:23 as the exponent field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_sig | input | 27 | Significand: hidden bit, 23 fraction bits, 3 extra bits |
| rnd_mode | input | 2 | Rounding mode, encoding as in R3 |
| flush_en | input | 1 | Flush tiny values instead of denormalizing |
| uf_trap_en | input | 1 | Underflow trap enabled (reports exact tiny results) |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Result was rounded |
| out_underflow | output | 1 | Tiny result per R6, R8, R9 |
| out_overflow | output | 1 | Exponent exceeded the format |

## Verification
There is one register between the input ports and every output. The packed word, all three flags and `out_valid` for an input presented before a rising edge are therefore due together just after that edge. The bench drives each input on a falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge. Its expected word comes from an integer model that divides the significand by a power of two, rounds the quotient and then looks up the special cases. The sweep covers every mode, sign, flush and trap setting against exponents clustered around the denormal, shortcut and overflow boundaries.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
    } flags_s;

endpackage

// File: rtl/rp_round_inc.sv
module rp_round_inc
    import rp_pkg::*;
#(
    parameter int SIG_W = 27
) (
    input  logic             sign,
    input  rmode_e           mode,
    input  logic [SIG_W-1:0] sig,
    output logic [SIG_W:0]   rounded
);
    logic [SIG_W:0] inc;

    always_comb begin
        inc = '0;
        if (|sig[2:0]) begin
            case (mode)
                RM_NEAR: inc = (SIG_W+1)'(3) + {{SIG_W{1'b0}}, sig[3]};
                RM_ZERO: inc = '0;
                RM_UP:   inc = sign ? '0 : (SIG_W+1)'(8);
                RM_DOWN: inc = sign ? (SIG_W+1)'(8) : '0;
                default: inc = '0;
            endcase
        end
        rounded = {1'b0, sig} + inc;
    end
endmodule

// File: rtl/rp_sticky_shr.sv
module rp_sticky_shr #(
    parameter int SIG_W = 27,
    parameter int SH_W  = 5
) (
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [SIG_W-1:0] sig_o
);
    logic [2*SIG_W-1:0] wide;

    always_comb begin
        wide  = {sig, {SIG_W{1'b0}}} >> shamt;
        sig_o = {wide[2*SIG_W-1:SIG_W+1], wide[SIG_W] | (|wide[SIG_W-1:0])};
    end
endmodule

// File: rtl/rp_special.sv
module rp_special
    import rp_pkg::*;
#(
    parameter int EXP_BITS = 8,
    parameter int FRAC_W   = 23
) (
    input  logic                       sign,
    input  rmode_e                     mode,
    output logic [EXP_BITS+FRAC_W:0]   ovf_word,
    output logic [EXP_BITS+FRAC_W:0]   ftz_word
);
    localparam int RES_W = 1 + EXP_BITS + FRAC_W;

    function automatic logic [RES_W-1:0] inf_w(input logic s);
        return {s, {EXP_BITS{1'b1}}, {FRAC_W{1'b0}}};
    endfunction
    function automatic logic [RES_W-1:0] max_w(input logic s);
        return {s, {(EXP_BITS-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    endfunction
    function automatic logic [RES_W-1:0] zero_w(input logic s);
        return {s, {(RES_W-1){1'b0}}};
    endfunction
    function automatic logic [RES_W-1:0] tiny_w(input logic s);
        return {s, {(RES_W-2){1'b0}}, 1'b1};
    endfunction

    always_comb begin
        case (mode)
            RM_NEAR: ovf_word = inf_w(sign);
            RM_ZERO: ovf_word = max_w(sign);
            RM_UP:   ovf_word = sign ? max_w(1'b1) : inf_w(1'b0);
            default: ovf_word = sign ? inf_w(1'b1) : max_w(1'b0);
        endcase
        case (mode)
            RM_UP:   ftz_word = sign ? zero_w(1'b1) : tiny_w(1'b0);
            RM_DOWN: ftz_word = sign ? tiny_w(1'b1) : zero_w(1'b0);
            default: ftz_word = zero_w(sign);
        endcase
    end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
    import rp_pkg::*;
#(
    parameter int EXP_BITS = 8,
    parameter int FRAC_W   = 23,
    parameter int XEXP_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sign,
    input  logic signed [XEXP_W-1:0] in_exp,
    input  logic [FRAC_W+3:0]        in_sig,
    input  logic [1:0]               rnd_mode,
    input  logic                     flush_en,
    input  logic                     uf_trap_en,
    output logic                     out_valid,
    output logic [EXP_BITS+FRAC_W:0] out_result,
    output logic                     out_inexact,
    output logic                     out_underflow,
    output logic                     out_overflow
);
    localparam int SIG_W = FRAC_W + 4;
    localparam int RES_W = 1 + EXP_BITS + FRAC_W;
    localparam int BIAS  = 2 ** (EXP_BITS - 1) - 1;
    localparam int EMIN  = 1 - BIAS;
    localparam int EMAX  = BIAS;
    localparam int IE_W  = XEXP_W + 2;
    localparam int SH_W  = $clog2(SIG_W + 1);
    localparam logic signed [IE_W-1:0] EMIN_V = IE_W'(EMIN);
    localparam logic signed [IE_W-1:0] EMAX_V = IE_W'(EMAX);
    localparam logic signed [IE_W-1:0] BIAS_V = IE_W'(BIAS);
    localparam logic signed [IE_W-1:0] SIGW_V = IE_W'(SIG_W);

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] res;
        flags_s           flg;
    } state_t;

    state_t st_d, st_q;
    rmode_e mode;

    logic signed [IE_W-1:0] xe, es, e1, e2;
    logic [SH_W-1:0]  shamt;
    logic [SIG_W:0]   pre_rnd, main_rnd;
    logic [SIG_W-1:0] shifted, s1, sig2;
    logic [FRAC_W:0]  mant;
    logic [RES_W-1:0] ovf_word, ftz_word;
    logic below, shortcut, extra_nz;

    assign mode = rmode_e'(rnd_mode);

    rp_round_inc #(.SIG_W(SIG_W)) u_pre_round (
        .sign(in_sign), .mode(mode), .sig(in_sig), .rounded(pre_rnd)
    );

    rp_sticky_shr #(.SIG_W(SIG_W), .SH_W(SH_W)) u_denorm (
        .sig(in_sig), .shamt(shamt), .sig_o(shifted)
    );

    rp_round_inc #(.SIG_W(SIG_W)) u_main_round (
        .sign(in_sign), .mode(mode), .sig(s1), .rounded(main_rnd)
    );

    rp_special #(.EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)) u_special (
        .sign(in_sign), .mode(mode), .ovf_word(ovf_word), .ftz_word(ftz_word)
    );

    // Stage 1: bring a tiny exponent up to the minimum.
    always_comb begin
        xe       = {{2{in_exp[XEXP_W-1]}}, in_exp};
        below    = xe < EMIN_V;
        es       = EMIN_V - xe;
        shamt    = (es > SIGW_V) ? SH_W'(SIG_W) : es[SH_W-1:0];
        shortcut = (xe == EMIN_V - IE_W'(1)) && pre_rnd[SIG_W];
        if (!below) begin
            s1 = in_sig;
            e1 = xe;
        end else if (shortcut) begin
            s1 = {pre_rnd[SIG_W:4], 3'b000};
            e1 = EMIN_V;
        end else begin
            s1 = shifted;
            e1 = EMIN_V;
        end
    end

    // Stage 2: round, follow carry, select special values, pack.
    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        extra_nz   = |s1[2:0];
        if (main_rnd[SIG_W]) begin
            sig2 = main_rnd[SIG_W:1];
            e2   = e1 + IE_W'(1);
        end else begin
            sig2 = main_rnd[SIG_W-1:0];
            e2   = e1;
        end
        mant = sig2[SIG_W-1:3];

        st_d.flg.inexact   = extra_nz | (below & shortcut);
        st_d.flg.underflow = extra_nz & ~s1[SIG_W-1];

        if (below && flush_en) begin
            st_d.res           = ftz_word;
            st_d.flg.inexact   = 1'b1;
            st_d.flg.underflow = 1'b1;
        end else if (e2 > EMAX_V) begin
            st_d.res          = ovf_word;
            st_d.flg.inexact  = 1'b1;
            st_d.flg.overflow = 1'b1;
        end else if (!mant[FRAC_W]) begin
            st_d.res = {in_sign, {EXP_BITS{1'b0}}, mant[FRAC_W-1:0]};
            if (uf_trap_en) st_d.flg.underflow = 1'b1;
        end else begin
            st_d.res = {in_sign, EXP_BITS'(e2 + BIAS_V), mant[FRAC_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign out_result    = st_q.res;
    assign out_inexact   = st_q.flg.inexact;
    assign out_underflow = st_q.flg.underflow;
    assign out_overflow  = st_q.flg.overflow;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_overflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> out_inexact);

    a_r6_flush_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flush_en && (in_exp < XEXP_W'(EMIN))) |=> (out_underflow && out_inexact));

    a_r9_trap_reports_tiny: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && uf_trap_en) |=> ((out_result[RES_W-2:FRAC_W] != '0) || out_underflow));

    a_r8_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow) |-> (out_inexact || (out_result[RES_W-2:FRAC_W] == '0)));

endmodule

// File: tb/sp_round_pack_test.sv
module sp_round_pack_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sign = 1'b0, flush_en = 1'b0, uf_trap_en = 1'b0;
    logic signed [9:0] in_exp = '0;
    logic [26:0] in_sig = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid, out_inexact, out_underflow, out_overflow;
    logic [31:0] out_result;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_round_pack uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode),
        .flush_en(flush_en), .uf_trap_en(uf_trap_en),
        .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_underflow(out_underflow),
        .out_overflow(out_overflow)
    );

    function automatic logic [31:0] w_inf(input logic s);  return {s, 8'hFF, 23'h0}; endfunction
    function automatic logic [31:0] w_max(input logic s);  return {s, 8'hFE, 23'h7FFFFF}; endfunction
    function automatic logic [31:0] w_zero(input logic s); return {s, 31'h0}; endfunction
    function automatic logic [31:0] w_tiny(input logic s); return {s, 31'h1}; endfunction

    function automatic bit up_dec(input int mode, input logic s, input longint q,
                                  input longint rem, input longint half);
        if (rem == 0) return 1'b0;
        case (mode)
            0: return (rem > half) || (rem == half && q[0]);
            1: return 1'b0;
            2: return !s;
            default: return s;
        endcase
    endfunction

    // Integer model: {result, inexact, underflow, overflow}, plus a requirement tag.
    function automatic logic [34:0] model(input logic s, input int e, input logic [26:0] sg,
                                          input int mode, input bit ftz, input bit trap,
                                          output string tag);
        longint x, q, rem, half, q0;
        int sh, er;
        bit ix, uf;
        logic [31:0] r;
        x = longint'(sg);
        if (e < -126 && ftz) begin
            tag = "R6";
            case (mode)
                2: r = s ? w_zero(1'b1) : w_tiny(1'b0);
                3: r = s ? w_tiny(1'b1) : w_zero(1'b0);
                default: r = w_zero(s);
            endcase
            return {r, 3'b110};
        end
        if (e == -127) begin
            q0 = x >> 3;
            if (q0 + longint'(up_dec(mode, s, q0, x & 7, 4)) == (64'sd1 << 24)) begin
                tag = "R7";
                return {s, 8'd1, 23'd0, 3'b100};
            end
        end
        sh   = (e < -126) ? (-126 - e) : 0;
        if (sh > 40) sh = 40;
        q    = x >> (sh + 3);
        rem  = x & ((64'sd1 << (sh + 3)) - 1);
        half = 64'sd1 << (sh + 2);
        ix   = (rem != 0);
        uf   = (sh > 0) && ix;
        tag  = ix ? ((mode == 0) ? "R4" : "R3") : "R12";
        if (ix && sh == 0 && mode == 0) tag = "R5";
        q    = q + longint'(up_dec(mode, s, q, rem, half));
        er   = (e < -126) ? -126 : e;
        if (q == (64'sd1 << 24)) begin
            q  = q >> 1;
            er = er + 1;
            tag = "R10";
        end
        if (er > 127) begin
            tag = "R11";
            case (mode)
                0: r = w_inf(s);
                1: r = w_max(s);
                2: r = s ? w_max(1'b1) : w_inf(1'b0);
                default: r = s ? w_inf(1'b1) : w_max(1'b0);
            endcase
            return {r, 3'b101};
        end
        if (q < (64'sd1 << 23)) begin
            tag = (trap && !ix) ? "R9" : "R8";
            if (trap) uf = 1'b1;
            r = {s, 8'd0, q[22:0]};
        end else begin
            if (sh > 0 && tag != "R10") tag = "R8";
            r = {s, 8'(er + 127), q[22:0]};
        end
        return {r, ix, uf, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got valid/result/ix/uf/ov=%h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic apply(input logic s, input int e, input logic [26:0] sg,
                         input int mode, input bit ftz, input bit trap);
        string tag;
        logic [34:0] ex;
        ex = model(s, e, sg, mode, ftz, trap, tag);
        in_valid = 1'b1; in_sign = s; in_exp = 10'(e); in_sig = sg;
        rnd_mode = 2'(mode); flush_en = ftz; uf_trap_en = trap;
        @(posedge clk);
        @(negedge clk);
        check(tag, {out_valid, out_result, out_inexact, out_underflow, out_overflow},
              {1'b1, ex});
    endtask

    function automatic logic [26:0] pattern(input int k);
        case (k)
            0:  return 27'h4000000;
            1:  return 27'h4000004;
            2:  return 27'h400000C;
            3:  return 27'h4000005;
            4:  return 27'h4000003;
            5:  return 27'h7FFFFFF;
            6:  return 27'h7FFFFFC;
            7:  return 27'h7FFFFF4;
            8:  return 27'h7FFFFF8;
            9:  return 27'h7FFFFF9;
            10: return 27'h4000010;
            11: return 27'h5A5A5A0;
            default: return {1'b1, 26'($urandom)};
        endcase
    endfunction

    function automatic int exp_pick(input int k);
        case (k)
            0: return -300;  1: return -160;  2: return -151;  3: return -150;
            4: return -149;  5: return -148;  6: return -130;  7: return -128;
            8: return -127;  9: return -126;  10: return -125; 11: return -1;
            12: return 0;    13: return 1;    14: return 126;  15: return 127;
            16: return 128;  default: return 200;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_result, out_inexact, out_underflow, out_overflow}, 36'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_result, out_inexact, out_underflow, out_overflow}, 36'h0);

        for (int m = 0; m < 4; m++)
            for (int sgn = 0; sgn < 2; sgn++)
                for (int f = 0; f < 2; f++)
                    for (int t = 0; t < 2; t++)
                        for (int ei = 0; ei < 18; ei++)
                            for (int pk = 0; pk < 16; pk++)
                                apply(sgn[0], exp_pick(ei), pattern(pk), m, f[0], t[0]);

        // R2: no input gives no output valid
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2: got out_valid=%b expected 0", out_valid);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule